// File: doc/BRIEF.md
# Host-to-Controller Mailbox Port

This block is a two-location mailbox between a host CPU bus and the bus of a companion microcontroller. The host uses a single-bit offset. At offset 0 it writes a byte for the controller, and it reads back the controller's most recent reply. At offset 1 it reads a status byte with two handshake flags. A write to offset 1 raises an interrupt request towards the controller, whatever the data is.

The controller side has three strobes: a data read, a data write and an interrupt acknowledge. The request stays raised until the controller acknowledges it. A static configuration pin chooses whether a host data write also raises the request by itself, or whether the host must raise it explicitly with a write to offset 1.

Both buses are single-cycle register accesses, not streams. Each strobe is honoured in the cycle it is presented, and neither side can be stalled. A new write simply replaces an unread byte. Back-pressure is left to software, which uses the two flags. All state resets synchronously.

Top module: `mbox_port`

## Requirements
- R1: A host write at offset 0 stores its data byte, and from the next cycle onward `mcu_rdata` returns that byte.
- R2: A host read at offset 0 returns, combinationally, the byte that the last controller write stored. The value is 0 if nothing has been stored since reset.
- R3: A host read at offset 1 returns the status byte: bit 0 is the accepted flag, bit 1 is the ready flag, and bits 7 to 2 are 0.
- R4: The accepted flag clears one cycle after a host write at offset 0 and sets one cycle after a controller read strobe. When both happen in the same cycle, the clear wins.
- R5: The ready flag sets one cycle after a controller write strobe and clears one cycle after a host read at offset 0. When both happen in the same cycle, the set wins.
- R6: A host write at offset 1 raises `mcu_irq` in the next cycle, for any data value.
- R7: When `auto_irq_en` is 1, a host write at offset 0 raises `mcu_irq` in the next cycle. When it is 0, a data write leaves `mcu_irq` unchanged.
- R8: `mcu_irq` stays high until a cycle with `mcu_ack`, and it is low in the cycle after that. If a raise and an acknowledge arrive in the same cycle, the raise wins.
- R9: A synchronous reset clears both data latches, both flags and `mcu_irq`.
- R10: `host_rdata` is 0 in every cycle without a host read (`host_cs` high with `host_we` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| auto_irq_en | input | 1 | Static: a host data write also raises the interrupt |
| host_cs | input | 1 | Host access strobe |
| host_we | input | 1 | Host access is a write |
| host_addr | input | 1 | Host offset: 0 data, 1 status/interrupt |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Host read data (0 when not reading) |
| mcu_rd | input | 1 | Controller data read strobe |
| mcu_wr | input | 1 | Controller data write strobe |
| mcu_wdata | input | 8 | Controller write data |
| mcu_rdata | output | 8 | Byte last written by the host |
| mcu_ack | input | 1 | Controller interrupt acknowledge |
| mcu_irq | output | 1 | Interrupt request to the controller |

## Verification
A directed phase covers each handshake in isolation:
- a host write followed by a controller read, which shows the accepted flag falling and then rising;
- a controller write followed by a host read, which shows the ready flag rising and then falling;
- data writes with the auto-interrupt pin at each level, which separates R7 from the explicit strobe of R6.

Same-cycle collisions are driven on purpose: write with read on each flag, and raise with acknowledge on the interrupt. These expose which event takes priority. A long random phase then mixes all strobes on both buses. A mid-run reset checks that every latch returns to zero.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  // host offset decode
  typedef enum logic {
    OFS_DATA = 1'b0,
    OFS_STAT = 1'b1
  } mbox_ofs_e;

  // status byte bit positions (software decodes these)
  localparam int STAT_ACC_BIT = 0;
  localparam int STAT_RDY_BIT = 1;
  localparam int STAT_FLAGS   = 2;

  typedef struct packed {
    logic rd_data;
    logic wr_data;
    logic rd_stat;
    logic wr_stat;
  } host_op_t;

endpackage

// File: rtl/mbox_host_dec.sv
module mbox_host_dec
  import mbox_pkg::*;
(
  input  logic     host_cs,
  input  logic     host_we,
  input  logic     host_addr,
  output host_op_t op
);

  logic is_data;

  always_comb begin
    is_data    = (host_addr == OFS_DATA);
    op.rd_data = host_cs & ~host_we &  is_data;
    op.wr_data = host_cs &  host_we &  is_data;
    op.rd_stat = host_cs & ~host_we & ~is_data;
    op.wr_stat = host_cs &  host_we & ~is_data;
  end

endmodule

// File: rtl/mbox_latch.sv
module mbox_latch #(
  parameter int DATA_W       = 8,
  parameter bit FLAG_ON_LOAD = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  input  logic              consume,
  output logic [DATA_W-1:0] dout,
  output logic              flag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (load) begin
      dout <= din;
    end
  end

  generate
    if (FLAG_ON_LOAD) begin : g_set_on_load
      // loading sets the flag; consumption clears it; load wins
      always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (load)    flag <= 1'b1;
        else if (consume) flag <= 1'b0;
      end
    end else begin : g_clr_on_load
      // loading clears the flag; consumption sets it; load wins
      always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (load)    flag <= 1'b0;
        else if (consume) flag <= 1'b1;
      end
    end
  endgenerate

endmodule

// File: rtl/mbox_irq.sv
module mbox_irq
  import mbox_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     auto_en,
  input  host_op_t op,
  input  logic     ack,
  output logic     irq
);

  logic raise;

  always_comb begin
    raise = op.wr_stat | (auto_en & op.wr_data);
  end

  always_ff @(posedge clk) begin
    if (rst)        irq <= 1'b0;
    else if (raise) irq <= 1'b1;
    else if (ack)   irq <= 1'b0;
  end

endmodule

// File: rtl/mbox_port.sv
module mbox_port
  import mbox_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              auto_irq_en,
  input  logic              host_cs,
  input  logic              host_we,
  input  logic              host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              mcu_rd,
  input  logic              mcu_wr,
  input  logic [DATA_W-1:0] mcu_wdata,
  output logic [DATA_W-1:0] mcu_rdata,
  input  logic              mcu_ack,
  output logic              mcu_irq
);

  localparam int STAT_PAD = DATA_W - STAT_FLAGS;

  host_op_t          op;
  logic              acc_q;
  logic              rdy_q;
  logic [DATA_W-1:0] m2h_q;
  logic [DATA_W-1:0] stat_w;

  mbox_host_dec dec_i (
    .host_cs  (host_cs),
    .host_we  (host_we),
    .host_addr(host_addr),
    .op       (op)
  );

  // host -> controller byte; flag = accepted
  mbox_latch #(.DATA_W(DATA_W), .FLAG_ON_LOAD(1'b0)) h2m_i (
    .clk    (clk),
    .rst    (rst),
    .load   (op.wr_data),
    .din    (host_wdata),
    .consume(mcu_rd),
    .dout   (mcu_rdata),
    .flag   (acc_q)
  );

  // controller -> host byte; flag = ready
  mbox_latch #(.DATA_W(DATA_W), .FLAG_ON_LOAD(1'b1)) m2h_i (
    .clk    (clk),
    .rst    (rst),
    .load   (mcu_wr),
    .din    (mcu_wdata),
    .consume(op.rd_data),
    .dout   (m2h_q),
    .flag   (rdy_q)
  );

  mbox_irq irq_i (
    .clk    (clk),
    .rst    (rst),
    .auto_en(auto_irq_en),
    .op     (op),
    .ack    (mcu_ack),
    .irq    (mcu_irq)
  );

  always_comb begin
    stat_w = {{STAT_PAD{1'b0}}, rdy_q, acc_q};
    if (op.rd_data)      host_rdata = m2h_q;
    else if (op.rd_stat) host_rdata = stat_w;
    else                 host_rdata = '0;
  end

endmodule

// File: rtl/mbox_port_chk.sv
module mbox_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              auto_irq_en,
  input logic              host_cs,
  input logic              host_we,
  input logic              host_addr,
  input logic [DATA_W-1:0] host_wdata,
  input logic [DATA_W-1:0] host_rdata,
  input logic              mcu_rd,
  input logic              mcu_wr,
  input logic [DATA_W-1:0] mcu_rdata,
  input logic              mcu_ack,
  input logic              mcu_irq,
  input logic              acc_flag,
  input logic              rdy_flag
);

  logic wr0, wr1, rd0, rd1;
  assign wr0 = host_cs &  host_we & ~host_addr;
  assign wr1 = host_cs &  host_we &  host_addr;
  assign rd0 = host_cs & ~host_we & ~host_addr;
  assign rd1 = host_cs & ~host_we &  host_addr;

  p_data_store_r1: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> mcu_rdata == $past(host_wdata));

  p_stat_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
    rd1 |-> host_rdata[DATA_W-1:2] == '0);

  p_acc_clear_r4: assert property (@(posedge clk) disable iff (rst)
    wr0 |=> !acc_flag);

  p_acc_set_r4: assert property (@(posedge clk) disable iff (rst)
    (mcu_rd && !wr0) |=> acc_flag);

  p_rdy_set_r5: assert property (@(posedge clk) disable iff (rst)
    mcu_wr |=> rdy_flag);

  p_rdy_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (rd0 && !mcu_wr) |=> !rdy_flag);

  p_irq_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    wr1 |=> mcu_irq);

  p_irq_auto_r7: assert property (@(posedge clk) disable iff (rst)
    (wr0 && auto_irq_en) |=> mcu_irq);

  p_irq_noauto_r7: assert property (@(posedge clk) disable iff (rst)
    (wr0 && !auto_irq_en && !wr1 && !mcu_ack) |=> (mcu_irq == $past(mcu_irq)));

  p_irq_ack_r8: assert property (@(posedge clk) disable iff (rst)
    (mcu_ack && !wr1 && !(wr0 && auto_irq_en)) |=> !mcu_irq);

  p_irq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mcu_irq && !mcu_ack) |=> mcu_irq);

  p_reset_clear_r9: assert property (@(posedge clk)
    rst |=> (!mcu_irq && !acc_flag && !rdy_flag && mcu_rdata == '0));

  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !(host_cs && !host_we) |-> host_rdata == '0);

endmodule

bind mbox_port mbox_port_chk #(.DATA_W(DATA_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .auto_irq_en(auto_irq_en),
  .host_cs    (host_cs),
  .host_we    (host_we),
  .host_addr  (host_addr),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .mcu_rd     (mcu_rd),
  .mcu_wr     (mcu_wr),
  .mcu_rdata  (mcu_rdata),
  .mcu_ack    (mcu_ack),
  .mcu_irq    (mcu_irq),
  .acc_flag   (acc_q),
  .rdy_flag   (rdy_q)
);

// File: tb/mbox_port_tb.sv
module mbox_port_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       auto_irq_en = 1'b0;
  logic       host_cs = 1'b0, host_we = 1'b0, host_addr = 1'b0;
  logic [7:0] host_wdata = 8'h00;
  logic [7:0] host_rdata;
  logic       mcu_rd = 1'b0, mcu_wr = 1'b0, mcu_ack = 1'b0;
  logic [7:0] mcu_wdata = 8'h00;
  logic [7:0] mcu_rdata;
  logic       mcu_irq;

  always #2 clk = ~clk;

  mbox_port dut_i (
    .clk(clk), .rst(rst), .auto_irq_en(auto_irq_en),
    .host_cs(host_cs), .host_we(host_we), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .mcu_rd(mcu_rd), .mcu_wr(mcu_wr), .mcu_wdata(mcu_wdata),
    .mcu_rdata(mcu_rdata), .mcu_ack(mcu_ack), .mcu_irq(mcu_irq)
  );

  // behavioural reference state
  int m_h2m, m_m2h, m_acc, m_rdy, m_irq;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: drive at negedge, compare before posedge, advance model
  task automatic step(input bit r, input bit cs, input bit we, input bit a,
                      input int hw, input bit rd, input bit wr, input int mw,
                      input bit ack);
    int exp_rd;
    bit wr0, wr1, rd0;
    rst = r; host_cs = cs; host_we = we; host_addr = a;
    host_wdata = hw[7:0]; mcu_rd = rd; mcu_wr = wr; mcu_wdata = mw[7:0];
    mcu_ack = ack;
    #1;
    wr0 = cs && we && !a;
    wr1 = cs && we && a;
    rd0 = cs && !we && !a;
    if (cs && !we) begin
      exp_rd = a ? (m_rdy * 2 + m_acc) : m_m2h;
      if (a) check("R3 R4 R5 status", int'(host_rdata), exp_rd);
      else   check("R2 host data read", int'(host_rdata), exp_rd);
    end else begin
      check("R10 idle read bus", int'(host_rdata), 0);
    end
    check("R1 R9 controller data", int'(mcu_rdata), m_h2m);
    check("R6 R7 R8 R9 irq", int'(mcu_irq), m_irq);
    @(posedge clk);
    if (r) begin
      m_h2m = 0; m_m2h = 0; m_acc = 0; m_rdy = 0; m_irq = 0;
    end else begin
      if (wr0) begin m_h2m = hw & 255; m_acc = 0; end
      else if (rd) m_acc = 1;
      if (wr) begin m_m2h = mw & 255; m_rdy = 1; end
      else if (rd0) m_rdy = 0;
      if (wr1 || (wr0 && auto_irq_en)) m_irq = 1;
      else if (ack) m_irq = 0;
    end
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic rd_stat();
    step(0, 1, 0, 1, 0, 0, 0, 0, 0);
  endtask

  initial begin
    m_h2m = 0; m_m2h = 0; m_acc = 0; m_rdy = 0; m_irq = 0;
    @(negedge clk);
    // R9 reset state
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    step(1, 0, 0, 0, 0, 0, 0, 0, 0);
    rd_stat();
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);          // R2 read of empty latch
    // R1 R4 host write, then controller read, no auto irq (R7 off)
    step(0, 1, 1, 0, 8'hA5, 0, 0, 0, 0);
    rd_stat();
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    rd_stat();
    // R5 R2 controller write then host read
    step(0, 0, 0, 0, 0, 0, 1, 8'h3C, 0);
    rd_stat();
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    rd_stat();
    // R6 strobe irq with arbitrary data, hold, then R8 ack
    step(0, 1, 1, 1, 8'hFF, 0, 0, 0, 0);
    idle(3);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    // R8 raise and ack in same cycle: raise wins
    step(0, 1, 1, 1, 8'h00, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    // R4 collision: host write with controller read -> clear wins
    step(0, 0, 0, 0, 0, 1, 0, 0, 0);
    step(0, 1, 1, 0, 8'h11, 1, 0, 0, 0);
    rd_stat();
    // R5 collision: controller write with host read -> set wins
    step(0, 1, 0, 0, 0, 0, 1, 8'h77, 0);
    rd_stat();
    step(0, 1, 0, 0, 0, 0, 0, 0, 0);
    // R7 auto interrupt on data write
    auto_irq_en = 1'b1;
    step(0, 1, 1, 0, 8'h5A, 0, 0, 0, 0);
    idle(2);
    step(0, 1, 1, 0, 8'h5B, 0, 0, 0, 1);      // raise beats ack
    step(0, 0, 0, 0, 0, 0, 0, 0, 1);
    idle(1);
    // random mix, both config levels, with a mid-run reset
    for (int ph = 0; ph < 2; ph++) begin
      auto_irq_en = ph[0];
      for (int i = 0; i < 600; i++) begin
        step(($urandom % 97) == 0, $urandom % 2, $urandom % 2, $urandom % 2,
             int'($urandom % 256), ($urandom % 3) == 0, ($urandom % 3) == 0,
             int'($urandom % 256), ($urandom % 4) == 0);
      end
      step(1, 0, 0, 0, 0, 0, 0, 0, 0);        // R9
      rd_stat();
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule